// File: doc/BRIEF.md
# Selector-Indexed Configuration Item Reader

The block gives a host a narrow register window onto a fixed set of read-only byte arrays called configuration items. The host first writes a 16-bit value to the selector register to pick an item. It then reads the data register one byte or four bytes at a time. The block keeps a hidden byte offset for the selected item. Each selector write clears the offset to zero, and each data read moves it forward by the number of bytes the read returned. Once the offset reaches the end of the item, every further byte reads back as zero. This lets firmware pull an item of any length with a simple loop and no length bookkeeping.

The item contents come from a small internal table computed in logic:
- a four-byte signature item at index 0;
- a four-byte feature bitmap at index 1;
- a generic test item at index 2;
- one item at index 0 of the architecture-specific space.

A selector that names no item behaves as an empty item. Writes to the data register are accepted on the port and then dropped.

The port uses a single-beat valid/ready handshake. Each accepted request produces exactly one response beat in the following cycle. Reset is asserted asynchronously and released through a two-stage synchronizer, and the port stays not-ready until that release has completed.

Top module: `cfg_item_port`

## Requirements
- R1: While reset is asserted, and for the two cycles after it is released, `req_ready` and `rsp_valid` are low. After reset the selector is 0x0000 and the offset is zero, so a selector read returns 0 and the first data byte is the first signature byte.
- R2: A write to register 0 (`req_addr`=0) loads `req_wdata` into the selector and clears the offset to zero. A read of register 0 returns the selector in bits 15:0 with bits 31:16 at zero, and it leaves the offset unchanged.
- R3: A byte data read (`req_addr`=1, `req_size`=0) returns the byte at the current offset in bits 7:0, with bits 31:8 at zero. It advances the offset by 1.
- R4: A word data read (`req_size`=1) returns the bytes at offsets o, o+1, o+2 and o+3 in bits 7:0, 15:8, 23:16 and 31:24 respectively. It advances the offset by 4.
- R5: Any byte at an offset at or beyond the item length reads as 0x00. A word read that straddles the end of an item returns the valid bytes followed by zeros, and the offset still advances by 4.
- R6: Selector bit 15 picks the space (0 = generic, 1 = architecture-specific), bits 13:0 give the index, and bit 14 does not affect which item is read. Generic index 2 is a 7-byte item whose byte i is 0xA0+i. Architecture index 0 is a 5-byte item whose byte i is 0x50 XOR (3·i mod 256).
- R7: A data-register write, of either size, changes neither the offset nor the selector, and produces a response with zero data.
- R8: Generic index 0 is the 4-byte signature 0x43, 0x46, 0x47, 0x21 at offsets 0 to 3.
- R9: Generic index 1 is a 4-byte little-endian feature bitmap. Bit 0 is 1 and bit 1 is the DMA-present parameter (0 by default), so the bytes are 0x01, 0x00, 0x00, 0x00.
- R10: A selector that names no item acts as a zero-length item, so every data read returns zero.
- R11: The offset saturates at its maximum value (255 by default) and never wraps, so item data does not reappear after a long run of reads.
- R12: Outside reset, `req_ready` is high, and `rsp_valid` is high in exactly the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = selector register, 1 = data register |
| req_size | input | 1 | 0 = byte access, 1 = 32-bit access |
| req_wdata | input | 16 | Selector value for selector writes; ignored for data writes |
| rsp_valid | output | 1 | Response beat, one cycle after acceptance |
| rsp_rdata | output | 32 | Response data, lowest offset in the lowest byte lane |

## Verification
Every selector of interest is walked with three read patterns: all bytes, aligned words, and a single byte followed by words.
- The all-byte pattern pins down each item's contents and the exact position of its end.
- The aligned-word pattern shows that byte lanes are ordered by offset.
- The byte-then-word pattern produces unaligned words that straddle the end of the item, which separates a design that truncates correctly from one that pads or shifts lanes.

The selector sweep covers:
- both spaces;
- the bit-14 aliases;
- unknown indices.

A long run of word reads shows that the offset saturates rather than wraps. Data writes inserted between reads show that the offset and the selector are left untouched.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

  typedef enum logic [2:0] {
    ITEM_NONE,
    ITEM_SIG,
    ITEM_FEAT,
    ITEM_GEN,
    ITEM_ARCH
  } item_e;

  localparam logic REG_SEL  = 1'b0;
  localparam logic REG_DATA = 1'b1;
  localparam logic SZ_BYTE  = 1'b0;
  localparam logic SZ_WORD  = 1'b1;

  // bytes consumed by one data access
  function automatic logic [2:0] access_bytes(input logic sz);
    return (sz == SZ_WORD) ? 3'd4 : 3'd1;
  endfunction

endpackage

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode
  import cfg_item_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int GEN_LEN  = 7,
  parameter int ARCH_LEN = 5
) (
  input  logic             arch_space,
  input  logic [13:0]      index,
  output item_e            kind,
  output logic [LEN_W-1:0] len
);

  localparam logic [LEN_W-1:0] L_SIG  = LEN_W'(4);
  localparam logic [LEN_W-1:0] L_FEAT = LEN_W'(4);
  localparam logic [LEN_W-1:0] L_GEN  = LEN_W'(GEN_LEN);
  localparam logic [LEN_W-1:0] L_ARCH = LEN_W'(ARCH_LEN);

  always_comb begin
    kind = ITEM_NONE;
    len  = '0;
    if (!arch_space) begin
      unique case (index)
        14'd0: begin kind = ITEM_SIG;  len = L_SIG;  end
        14'd1: begin kind = ITEM_FEAT; len = L_FEAT; end
        14'd2: begin kind = ITEM_GEN;  len = L_GEN;  end
        default: begin kind = ITEM_NONE; len = '0; end
      endcase
    end else if (index == 14'd0) begin
      kind = ITEM_ARCH;
      len  = L_ARCH;
    end
  end

endmodule

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
  import cfg_item_pkg::*;
#(
  parameter int          OFS_W       = 8,
  parameter int          LANES       = 4,
  parameter logic [31:0] SIG         = 32'h2147_4643,
  parameter bit          DMA_PRESENT = 1'b0
) (
  input  item_e                kind,
  input  logic [OFS_W-1:0]     len,
  input  logic [OFS_W-1:0]     base,
  output logic [8*LANES-1:0]   word
);

  localparam logic [7:0] FEAT_B0 = {6'b0, DMA_PRESENT, 1'b1};

  function automatic logic [7:0] item_byte(input item_e k, input logic [OFS_W-1:0] p);
    logic [7:0] p8;
    logic [7:0] r;
    p8 = 8'(p);
    r  = 8'h00;
    unique case (k)
      ITEM_SIG:  r = 8'(SIG >> {p[1:0], 3'b000});
      ITEM_FEAT: r = (p == '0) ? FEAT_B0 : 8'h00;
      ITEM_GEN:  r = 8'hA0 + p8;
      ITEM_ARCH: r = 8'h50 ^ 8'(p8 * 8'd3);
      default:   r = 8'h00;
    endcase
    return r;
  endfunction

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [OFS_W:0] pos;
    logic           in_range;
    always_comb begin
      pos      = {1'b0, base} + (OFS_W+1)'(ln);
      in_range = (pos < {1'b0, len});
      word[8*ln +: 8] = in_range ? item_byte(kind, pos[OFS_W-1:0]) : 8'h00;
    end
  end

endmodule

// File: rtl/cfg_offset_ctr.sv
module cfg_offset_ctr #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [2:0]       step,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [OFS_W:0]   sum;
  logic             en;

  always_comb begin
    sum   = {1'b0, ofs_q} + (OFS_W+1)'(step);
    en    = clr | adv;
    ofs_d = ofs_q;
    if (clr)      ofs_d = '0;
    else if (adv) ofs_d = sum[OFS_W] ? '1 : sum[OFS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ofs_q <= '0;
    else if (en) ofs_q <= ofs_d;
  end

  assign ofs = ofs_q;

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_item_pkg::*;
#(
  parameter int          OFS_W       = 8,
  parameter int          GEN_LEN     = 7,
  parameter int          ARCH_LEN    = 5,
  parameter logic [31:0] SIG         = 32'h2147_4643,
  parameter bit          DMA_PRESENT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_addr,
  input  logic        req_size,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);

  localparam int LANES = 4;

  // reset release synchronizer
  logic [1:0] rst_pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign req_ready = rst_pipe[1];

  logic accept, sel_wr, sel_rd, data_rd;
  always_comb begin
    accept  = req_valid & req_ready;
    sel_wr  = accept &  req_write & (req_addr == REG_SEL);
    sel_rd  = accept & ~req_write & (req_addr == REG_SEL);
    data_rd = accept & ~req_write & (req_addr == REG_DATA);
  end

  // selector register
  logic [15:0] sel_q, sel_d;
  always_comb sel_d = req_wdata;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 16'h0000;
    else if (sel_wr) sel_q <= sel_d;
  end

  item_e            cur_kind;
  logic [OFS_W-1:0] cur_len;
  logic [OFS_W-1:0] ofs_q;
  logic [31:0]      rom_word;

  cfg_sel_decode #(
    .LEN_W   (OFS_W),
    .GEN_LEN (GEN_LEN),
    .ARCH_LEN(ARCH_LEN)
  ) u_dec (
    .arch_space(sel_q[15]),
    .index     (sel_q[13:0]),
    .kind      (cur_kind),
    .len       (cur_len)
  );

  cfg_item_rom #(
    .OFS_W      (OFS_W),
    .LANES      (LANES),
    .SIG        (SIG),
    .DMA_PRESENT(DMA_PRESENT)
  ) u_rom (
    .kind(cur_kind),
    .len (cur_len),
    .base(ofs_q),
    .word(rom_word)
  );

  cfg_offset_ctr #(.OFS_W(OFS_W)) u_ofs (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (sel_wr),
    .adv  (data_rd),
    .step (access_bytes(req_size)),
    .ofs  (ofs_q)
  );

  // response path
  logic [31:0] rdata_d, rdata_q;
  logic        rvalid_q;
  always_comb begin
    rdata_d = 32'h0;
    if (data_rd)     rdata_d = (req_size == SZ_WORD) ? rom_word : {24'h0, rom_word[7:0]};
    else if (sel_rd) rdata_d = {16'h0, sel_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= 32'h0;
    end else begin
      rvalid_q <= accept;
      if (accept) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_addr,
  input logic             req_size,
  input logic [15:0]      req_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [OFS_W-1:0] ofs,
  input logic [OFS_W-1:0] len,
  input logic [15:0]      sel
);

  logic acc, rd_data, wr_data, wr_sel;
  assign acc     = req_valid & req_ready;
  assign rd_data = acc & ~req_write & req_addr;
  assign wr_data = acc &  req_write & req_addr;
  assign wr_sel  = acc &  req_write & ~req_addr;

  AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rsp_valid); // R1

  AST_SEL_CLEARS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (ofs == '0) && (sel == $past(req_wdata))); // R2

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !req_size && (ofs != '1)) |=> (ofs == $past(ofs) + 1'b1)); // R3

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !req_size) |=> (rsp_rdata[31:8] == 24'h0)); // R3

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && req_size && (ofs[OFS_W-1:2] != '1)) |=> (ofs == $past(ofs) + 3'd4)); // R4

  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && (ofs >= len)) |=> (rsp_rdata == 32'h0)); // R5

  AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (ofs == $past(ofs)) && (sel == $past(sel)) && (rsp_rdata == 32'h0)); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> (ofs >= $past(ofs))); // R11

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(acc)); // R12

endmodule

bind cfg_item_port cfg_item_port_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_size (req_size),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .ofs      (ofs_q),
  .len      (cur_len),
  .sel      (sel_q)
);

// File: tb/cfg_item_port_test.sv
module cfg_item_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_addr, req_size;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  int m_ofs;
  logic [15:0] m_sel;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_item_port uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int mlen(input logic [15:0] s);
    if (!s[15]) begin
      if (s[13:0] == 14'd0) return 4;
      if (s[13:0] == 14'd1) return 4;
      if (s[13:0] == 14'd2) return 7;
      return 0;
    end
    return (s[13:0] == 14'd0) ? 5 : 0;
  endfunction

  function automatic logic [7:0] mbyte(input logic [15:0] s, input int o);
    logic [7:0] sig [4];
    sig[0] = 8'h43; sig[1] = 8'h46; sig[2] = 8'h47; sig[3] = 8'h21;
    if (o >= mlen(s)) return 8'h00;
    if (s[15]) return 8'h50 ^ 8'((o * 3) % 256);
    if (s[13:0] == 14'd0) return sig[o];
    if (s[13:0] == 14'd1) return (o == 0) ? 8'h01 : 8'h00;
    return 8'(8'hA0 + o);
  endfunction

  task automatic access(input logic w, input logic a, input logic sz,
                        input logic [15:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 rsp_valid after request", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic do_sel(input logic [15:0] v);
    logic [31:0] rd;
    access(1'b1, 1'b0, 1'b0, v, rd);
    m_sel = v;
    m_ofs = 0;
  endtask

  task automatic do_rd(input logic sz, input string tag);
    logic [31:0] rd, exp;
    int n;
    n   = sz ? 4 : 1;
    exp = 32'h0;
    for (int i = 0; i < n; i++) exp[8*i +: 8] = mbyte(m_sel, m_ofs + i);
    access(1'b0, 1'b1, sz, 16'h0, rd);
    check($sformatf("%s %s sel=%04h ofs=%0d", sz ? "R4" : "R3", tag, m_sel, m_ofs), rd, exp);
    m_ofs = (m_ofs + n > 255) ? 255 : m_ofs + n;
  endtask

  function automatic string tag_for(input logic [15:0] s);
    if (mlen(s) == 0) return "R10";
    if (!s[15] && s[13:0] == 14'd0) return "R8";
    if (!s[15] && s[13:0] == 14'd1) return "R9";
    return "R6";
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] sels [10];
    sels[0] = 16'h0000; sels[1] = 16'h4000; sels[2] = 16'h0001; sels[3] = 16'h0002;
    sels[4] = 16'h4002; sels[5] = 16'h8000; sels[6] = 16'hC000; sels[7] = 16'h0003;
    sels[8] = 16'h8001; sels[9] = 16'h3FFF;
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {31'b0, req_ready}, 32'd0);
    check("R1 rsp_valid low in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready low after release", {31'b0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    check("R12 ready high", {31'b0, req_ready}, 32'd1);

    // R1: reset selector and offset
    access(1'b0, 1'b0, 1'b0, 16'h0, rd);
    check("R1 selector after reset", rd, 32'h0);
    m_sel = 16'h0000; m_ofs = 0;
    do_rd(1'b0, "R1 first byte after reset");
    @(negedge clk);
    check("R12 no response when idle", {31'b0, rsp_valid}, 32'd0);

    // sweep: three read patterns per selector
    for (int s = 0; s < 10; s++) begin
      do_sel(sels[s]);
      for (int k = 0; k < 10; k++) do_rd(1'b0, {tag_for(sels[s]), " R5 bytes"});
      do_sel(sels[s]);
      for (int k = 0; k < 3; k++) do_rd(1'b1, {tag_for(sels[s]), " R5 words"});
      do_sel(sels[s]);
      do_rd(1'b0, {tag_for(sels[s]), " mixed"});
      for (int k = 0; k < 2; k++) do_rd(1'b1, {tag_for(sels[s]), " R5 mixed"});
    end

    // R5: straddle end of 7-byte item from offset 5
    do_sel(16'h0002);
    for (int k = 0; k < 5; k++) do_rd(1'b0, "R5 lead");
    access(1'b0, 1'b1, 1'b1, 16'h0, rd);
    check("R5 straddle word", rd, 32'h0000_A6A5);
    access(1'b0, 1'b1, 1'b0, 16'h0, rd);
    check("R5 offset advanced by 4", rd, 32'h0);

    // R2: selector readback, selector read leaves offset alone
    do_sel(16'hC123);
    access(1'b0, 1'b0, 1'b0, 16'h0, rd);
    check("R2 selector readback", rd, 32'h0000_C123);
    do_sel(16'h0000);
    do_rd(1'b0, "R2 ofs0");
    access(1'b0, 1'b0, 1'b0, 16'h0, rd);
    check("R2 selector read", rd, 32'h0);
    do_rd(1'b0, "R2 ofs1 kept after selector read");
    do_sel(16'h0000);
    do_rd(1'b1, "R2 reselect clears offset");

    // R7: data writes have no effect
    do_sel(16'h0002);
    do_rd(1'b0, "R7 before write");
    access(1'b1, 1'b1, 1'b0, 16'hFFFF, rd);
    check("R7 byte write response", rd, 32'h0);
    access(1'b1, 1'b1, 1'b1, 16'hFFFF, rd);
    check("R7 word write response", rd, 32'h0);
    do_rd(1'b0, "R7 offset unchanged");
    access(1'b0, 1'b0, 1'b0, 16'h0, rd);
    check("R7 selector unchanged", rd, 32'h0000_0002);

    // R11: saturation, no wrap
    do_sel(16'h0000);
    for (int k = 0; k < 70; k++) do_rd(1'b1, "R11 long run");
    do_rd(1'b0, "R11 saturated byte");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule